// File: doc/BRIEF.md
# Cascadable Serial-In Converter Code Register

This block is the digital front end of a 12-bit serial-input converter. It is built for a fabric where all logic runs on one system clock. The serial clock, serial data, load strobe and clear pins pass through a synchronizer. Edges of the serial clock and of the strobe are then found by comparing samples.

While the active-low strobe is held low, each rising serial clock edge shifts one data bit into a shift register, most significant bit first. When the strobe goes back high, the whole word is copied into a held code register, which drives the converter. While the strobe is high, the serial clock is gated off.

The last stage of the shift register drives a serial output. A second device can take its serial input from that output and share the clock and strobe with the first, so a chain of N devices is loaded with 12×N clocks followed by one strobe rising edge. Holding the clear pin low empties both registers.

Top module: `sdac_front`

## Requirements
- R1: While `strobe_n` is low, `ser_in` is captured on each rising edge of `ser_clk`, one bit per edge.
- R2: Bits arrive most significant first. The 12th bit shifted before a load becomes bit 0 of `dac_code`, and the first becomes bit 11.
- R3: Both registers are WIDTH bits wide (default 12), so every code from 0 to 4095 can be loaded and held, including 0x000 and 0xFFF.
- R4: `dac_code` changes only when `strobe_n` goes from low to high, and then takes the shift register contents. In the middle of a frame it keeps its previous value.
- R5: While `strobe_n` is high, edges on `ser_clk` do not move the shift register. A later empty frame (strobe low, then high, with no clocks) reloads the unchanged word.
- R6: While `clear_n` is low, the shift register and `dac_code` are both zero, and so is `ser_out`.
- R7: Clear has priority over the strobe. A strobe rising edge seen while clear is low loads nothing, and both registers stay zero after clear is released.
- R8: `ser_out` is the last stage of the shift register. It changes only on a shifting edge or on a clear, and after a complete load it equals bit 11 of the loaded word.
- R9: For two devices in cascade, the first device's `ser_out` feeds the second device's `ser_in`. After 24 clocks and one strobe rising edge, the second device holds the first word sent and the first device holds the second.
- R10: If `ser_clk` is already high when `strobe_n` falls, the gated clock rises at that moment and one extra bit, the current `ser_in`, is shifted in.
- R11: A synchronous active-high `rst` clears both registers. Pin changes take effect SYNC_STAGES+1 system clocks after they are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; the active edge is the rising edge |
| ser_in | input | 1 | Serial data, most significant bit first |
| strobe_n | input | 1 | Active-low frame strobe; its rising edge loads the held code |
| clear_n | input | 1 | Active-low clear of both registers |
| dac_code | output | WIDTH | Held converter code |
| ser_out | output | 1 | Last shift-register stage, used for cascading |

## Verification
The assertions take for granted that every pin stays stable for at least SYNC_STAGES+2 system clocks between changes. Under that condition, each serial clock edge and each strobe edge is seen exactly once after synchronization. The stimulus holds every serial half period and every strobe phase for six system clocks.

Data is set up half a serial period before each rising clock edge. The cascaded device takes its input from a registered output that settles long before its next sampling point. Random words go only through well-formed frames. The extra-edge case is created on purpose, by raising the serial clock before the strobe falls.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef struct packed {
    logic ser_clk;
    logic ser_in;
    logic strobe_n;
    logic clear_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{ser_clk: 1'b0, ser_in: 1'b0, strobe_n: 1'b1, clear_n: 1'b1};
  localparam int    PINS_W    = $bits(pins_t);
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int              WIDTH  = 4,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= IDLE;
        else     chain_q[0] <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{IDLE}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_edges.sv
module sdac_edges (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk_s,
  input  logic strobe_n_s,
  input  logic clear_n_s,
  output logic shift_en,
  output logic load_en,
  output logic clear_act
);
  logic gated_clk;
  logic gated_q;
  logic strobe_q;

  // serial clock passes only while the strobe is low; a strobe fall with the
  // clock high therefore produces a rising edge of its own
  assign gated_clk = ser_clk_s & ~strobe_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      gated_q  <= 1'b0;
      strobe_q <= 1'b1;
    end else begin
      gated_q  <= gated_clk;
      strobe_q <= strobe_n_s;
    end
  end

  assign clear_act = ~clear_n_s;
  assign shift_en  = gated_clk & ~gated_q & clear_n_s;
  assign load_en   = strobe_n_s & ~strobe_q & clear_n_s;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] word,
  output logic             dout
);
  always_ff @(posedge clk) begin
    if (rst || clear)  word <= '0;
    else if (shift_en) word <= {word[WIDTH-2:0], din};
  end

  assign dout = word[WIDTH-1];

  assert_clear_empties_shift_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (word == '0));
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst || clear) code <= '0;
    else if (load_en) code <= d;
  end

  assert_hold_only_on_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !clear) |=> $stable(code));

  assert_clear_priority_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (code == '0));
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_in,
  input  logic             strobe_n,
  input  logic             clear_n,
  output logic [WIDTH-1:0] dac_code,
  output logic             ser_out
);
  import sdac_pkg::*;

  pins_t            pins_raw;
  pins_t            pins_s;
  logic [PINS_W-1:0] pins_vec;
  logic             shift_en;
  logic             load_en;
  logic             clear_act;
  logic [WIDTH-1:0] shift_word;

  assign pins_raw = '{ser_clk: ser_clk, ser_in: ser_in, strobe_n: strobe_n, clear_n: clear_n};

  sdac_sync #(.WIDTH(PINS_W), .STAGES(SYNC_STAGES), .IDLE(PINS_IDLE)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_vec)
  );
  assign pins_s = pins_t'(pins_vec);

  sdac_edges edges_i (
    .clk        (clk),
    .rst        (rst),
    .ser_clk_s  (pins_s.ser_clk),
    .strobe_n_s (pins_s.strobe_n),
    .clear_n_s  (pins_s.clear_n),
    .shift_en   (shift_en),
    .load_en    (load_en),
    .clear_act  (clear_act)
  );

  sdac_shift #(.WIDTH(WIDTH)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear_act),
    .shift_en (shift_en),
    .din      (pins_s.ser_in),
    .word     (shift_word),
    .dout     (ser_out)
  );

  sdac_hold #(.WIDTH(WIDTH)) hold_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear_act),
    .load_en (load_en),
    .d       (shift_word),
    .code    (dac_code)
  );

  assert_gated_when_high_R5: assert property (@(posedge clk) disable iff (rst)
    (pins_s.strobe_n && pins_s.clear_n) |=> $stable(shift_word));

  assert_ser_out_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !clear_act) |=> $stable(ser_out));
endmodule

// File: tb/sdac_front_tb_top.sv
module sdac_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;
  localparam int W          = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_in = 1'b0, strobe_n = 1'b1, clear_n = 1'b1;
  logic [W-1:0] code_a, code_b;
  logic sdo_a, sdo_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_front #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_in(ser_in),
    .strobe_n(strobe_n), .clear_n(clear_n), .dac_code(code_a), .ser_out(sdo_a));

  sdac_front #(.WIDTH(W)) dut_chain_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_in(sdo_a),
    .strobe_n(strobe_n), .clear_n(clear_n), .dac_code(code_b), .ser_out(sdo_b));

  function automatic logic [W-1:0] exp_extra(logic first, logic [W-2:0] rest);
    return {first, rest};
  endfunction

  function automatic logic exp_top_bit(logic [W-1:0] w);
    return w[W-1];
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    ser_in = b;
    wait_clk(HP);
    ser_clk = 1'b1;
    wait_clk(HP);
    ser_clk = 1'b0;
  endtask

  task automatic send_bits(logic [W-1:0] w, int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic begin_frame();
    strobe_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic end_frame();
    wait_clk(HP);
    strobe_n = 1'b1;
    wait_clk(HP);
  endtask

  initial begin
    logic [W-1:0] prev;
    logic [W-1:0] w;
    logic         sdo_before;

    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check("R11", "code after reset", 32'(code_a), 32'h0);
    check("R11", "ser_out after reset", 32'(sdo_a), 32'h0);

    // R1 / R2: ordinary frame
    begin_frame(); send_bits(12'hA5C, W); end_frame();
    check("R2", "msb-first word", 32'(code_a), 32'hA5C);
    check("R8", "ser_out shows bit 11", 32'(sdo_a), 32'(exp_top_bit(12'hA5C)));
    check("R9", "chain got old contents", 32'(code_b), 32'h0);

    // R3: extreme codes
    begin_frame(); send_bits(12'hFFF, W); end_frame();
    check("R3", "full scale", 32'(code_a), 32'hFFF);
    begin_frame(); send_bits(12'h000, W); end_frame();
    check("R3", "zero scale", 32'(code_a), 32'h000);

    // R4: held code keeps its value mid-frame
    begin_frame(); send_bits(12'h3C0 >> 6, 6);
    check("R4", "code mid-frame", 32'(code_a), 32'h000);
    send_bits(12'h3C0, 6); end_frame();
    check("R4", "code after load", 32'(code_a), 32'h3C0);

    // R5: clocks with the strobe high are blocked
    ser_in = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_clk(HP); ser_clk = 1'b1; wait_clk(HP); ser_clk = 1'b0;
    end
    wait_clk(HP);
    check("R5", "ser_out unmoved", 32'(sdo_a), 32'h0);
    check("R5", "code unmoved", 32'(code_a), 32'h3C0);
    begin_frame(); end_frame();
    check("R5", "empty frame reloads same word", 32'(code_a), 32'h3C0);

    // R8: data toggles without a clock do not reach ser_out
    begin_frame();
    sdo_before = sdo_a;
    for (int k = 0; k < 4; k++) begin ser_in = ~ser_in; wait_clk(HP); end
    check("R8", "ser_out stable without clock", 32'(sdo_a), 32'(sdo_before));
    end_frame();

    // R10: serial clock high when the strobe falls gives one extra shift
    ser_in = 1'b1;
    ser_clk = 1'b1;
    wait_clk(HP);
    strobe_n = 1'b0;
    wait_clk(HP);
    ser_clk = 1'b0;
    wait_clk(HP);
    send_bits(12'h155, W - 1);
    end_frame();
    check("R10", "extra bit as msb", 32'(code_a), 32'(exp_extra(1'b1, 11'h155)));

    // R6 / R7: clear mid-frame, then strobe during clear
    begin_frame(); send_bits(12'h01F, 5);
    clear_n = 1'b0;
    wait_clk(HP);
    check("R6", "code cleared", 32'(code_a), 32'h0);
    check("R6", "ser_out cleared", 32'(sdo_a), 32'h0);
    check("R6", "chain code cleared", 32'(code_b), 32'h0);
    strobe_n = 1'b1;
    wait_clk(HP);
    check("R7", "strobe during clear", 32'(code_a), 32'h0);
    clear_n = 1'b1;
    wait_clk(HP);
    check("R7", "after clear release", 32'(code_a), 32'h0);
    begin_frame(); end_frame();
    check("R7", "shift register still empty", 32'(code_a), 32'h0);

    // R9: two-device cascade, 24 bits and one strobe
    begin_frame(); send_bits(12'h9E3, W); send_bits(12'h47A, W); end_frame();
    check("R9", "near device", 32'(code_a), 32'h47A);
    check("R9", "far device", 32'(code_b), 32'h9E3);
    check("R9", "far ser_out", 32'(sdo_b), 32'(exp_top_bit(12'h9E3)));

    // R1: random words, cascade tracks previous word
    void'($urandom(32'd20240611));
    prev = 12'h47A;
    for (int n = 0; n < 20; n++) begin
      w = W'($urandom() & 32'hFFF);
      begin_frame(); send_bits(w, W); end_frame();
      check("R1", "random word", 32'(code_a), 32'(w));
      check("R9", "cascade previous word", 32'(code_b), 32'(prev));
      check("R8", "random ser_out", 32'(sdo_a), 32'(exp_top_bit(w)));
      prev = w;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule